// File: doc/BRIEF.md
# Nibble-Serial Sample Word Link

This block carries 16-bit two's-complement sample words between a modem signal processor and a converter core over two four-line nibble buses: one bus brings transmit words in, the other sends receive words out. Each word occupies four consecutive nibble slots. In slot s, lane k carries word bit 4s+k. A word strobe marks the first slot of every word. All timing comes from the master clock through a divider whose ratio N is 1, 2, 4 or 8. One slot lasts N master cycles and one word lasts 4N.

The whole block runs on the master clock. The nibble clock is brought out as a level for the far side. The two nibble-clock edges map to fixed cycles inside a slot: the rising edge is the slot boundary and the falling edge is the middle of the slot. Separate controls choose these points for each direction. For transmit, the control picks the cycle in which the incoming nibble is sampled. For receive, it picks the cycle in which the outgoing nibble changes.

A format control picks one or two sign bits. In the two-sign format, bit 14 repeats bit 15 on both paths. A loopback control feeds each deserialized transmit word back into the receive serializer.

Top module: `nwl_link`

## Requirements
- R1: While rst_n is low, word_stb_o is 1, tx_valid_o is 0 and rx_nib_o is 0. The registered divider code resets to 0 (N=1). The cycle in which reset is released is slot 0, phase 0 of the first word.
- R2: Divider code c on div_sel_i gives N = 2^c (0:1, 1:2, 2:4, 3:8). word_stb_o is high for the N cycles of slot 0 and low for the next 3N cycles, so its period is 4N.
- R3: nib_clk_o is constantly high when N=1. For N of 2 or more, it is high during the first N/2 cycles of every slot and low for the rest of the slot.
- R4: On both buses, the nibble in slot s (s=0..3) carries word bits 4s+3..4s, with lane k holding bit 4s+k.
- R5: tx_nib_i is sampled in slot phase N/2 when tx_rise_i=0, and in phase N-1 when tx_rise_i=1. After the slot-3 sample, tx_valid_o is high for exactly one cycle, together with the new tx_word_o. Counting the first strobe cycle of the word as cycle 0, that cycle is 3N + phase + 1. tx_word_o holds its value until the next pulse.
- R6: rx_nib_o changes only in slot phase 0 when rx_rise_i=0, and only in phase N/2 when rx_rise_i=1. For N=1 both settings give phase 0.
- R7: The receive word is taken from rx_word_i at the point where slot 0 is launched. It is held for the rest of the frame.
- R8: With one_sign_i=1, words pass unchanged. With one_sign_i=0, bit 14 is replaced by bit 15, on both the transmit and the receive path.
- R9: With loop_i=1, the receive source is tx_word_o and rx_word_i has no effect on rx_nib_o.
- R10: In a cycle where div_sel_i differs from its value in the previous cycle, the next cycle starts a new word at slot 0, phase 0 with the new N. The strobe is then high for N_new cycles. A transmit word that was partly assembled is dropped and produces no tx_valid_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | 2 | Divider code, N = 2^code |
| one_sign_i | input | 1 | 1: one sign bit, 0: two sign bits |
| tx_rise_i | input | 1 | Transmit sampling point: 0 mid-slot, 1 end of slot |
| rx_rise_i | input | 1 | Receive change point: 0 slot start, 1 mid-slot |
| loop_i | input | 1 | Feed deserialized transmit words into the receive serializer |
| tx_nib_i | input | 4 | Transmit nibble bus |
| tx_word_o | output | 16 | Last assembled transmit word |
| tx_valid_o | output | 1 | One-cycle pulse marking a new tx_word_o |
| rx_word_i | input | 16 | Receive word from the converter core |
| rx_nib_o | output | 4 | Receive nibble bus |
| word_stb_o | output | 1 | Word strobe, high during slot 0 |
| nib_clk_o | output | 1 | Nibble clock level |

## Verification
The bench finds each word start at the rising edge of word_stb_o and sets every expected cycle from that point. The transmit pulse is due 3N + phase + 1 cycles later. The bench records the cycle in which the pulse appears and compares the distance with that value, and it counts pulses so that a second or a missing pulse is caught. Receive nibbles are compared in every cycle of a frame: before the slot's change phase the bench expects the previous nibble, and from that phase on the new one. After a divider change, the bench expects the strobe high in the very next cycle and no pulse from the dropped word. All inputs are driven and all outputs sampled on the falling clock edge.

// File: rtl/nwl_pkg.sv
package nwl_pkg;
  localparam int WORD_W  = 16;
  localparam int LANES   = 4;
  localparam int SLOTS   = WORD_W / LANES;
  localparam int SEL_W   = 2;
  localparam int MAX_DIV = 1 << ((1 << SEL_W) - 1);
  localparam int PH_W    = $clog2(MAX_DIV);
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int N_W     = PH_W + 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  nib_t;
  typedef logic [PH_W-1:0]   phase_t;
  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [N_W-1:0]    ndiv_t;

  // division ratio from its code: 1, 2, 4, 8
  function automatic ndiv_t div_of(input logic [SEL_W-1:0] sel);
    return ndiv_t'(1) << sel;
  endfunction

  // slot phase at which an incoming nibble is taken
  function automatic ndiv_t sample_off(input ndiv_t n, input logic rise);
    return rise ? (n - ndiv_t'(1)) : (n >> 1);
  endfunction

  // slot phase at which an outgoing nibble changes
  function automatic ndiv_t launch_off(input ndiv_t n, input logic rise);
    return rise ? (n >> 1) : ndiv_t'(0);
  endfunction

  // sign format: two-sign mode repeats the sign into the bit below it
  function automatic word_t fmt_word(input word_t w, input logic one_sign);
    word_t r;
    r = w;
    if (!one_sign) r[WORD_W-2] = w[WORD_W-1];
    return r;
  endfunction

  function automatic nib_t nib_of(input word_t w, input slot_t s);
    return w[s*LANES +: LANES];
  endfunction
endpackage

// File: rtl/nwl_timebase.sv
module nwl_timebase
  import nwl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             tx_rise_i,
  input  logic             rx_rise_i,
  output phase_t           phase_o,
  output slot_t            slot_o,
  output ndiv_t            n_o,
  output logic             resync_o,
  output logic             tx_cap_o,
  output logic             rx_launch_o,
  output slot_t            nxt_slot_o,
  output logic             word_stb_o,
  output logic             nib_clk_o
);
  logic [SEL_W-1:0] div_q;
  phase_t           phase_q, nxt_phase;
  slot_t            slot_q, nxt_slot;
  ndiv_t            n_cur, n_eff;
  logic             resync, slot_end;

  assign n_cur    = div_of(div_q);
  assign resync   = (div_sel_i != div_q);
  assign n_eff    = resync ? div_of(div_sel_i) : n_cur;
  assign slot_end = (ndiv_t'(phase_q) == (n_cur - ndiv_t'(1)));

  always_comb begin
    if (resync) begin
      nxt_phase = '0;
      nxt_slot  = '0;
    end else if (slot_end) begin
      nxt_phase = '0;
      nxt_slot  = slot_q + slot_t'(1);
    end else begin
      nxt_phase = phase_q + phase_t'(1);
      nxt_slot  = slot_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      phase_q <= '0;
      slot_q  <= '0;
    end else begin
      div_q   <= div_sel_i;
      phase_q <= nxt_phase;
      slot_q  <= nxt_slot;
    end
  end

  assign tx_cap_o    = !resync && (ndiv_t'(phase_q) == sample_off(n_cur, tx_rise_i));
  assign rx_launch_o = (ndiv_t'(nxt_phase) == launch_off(n_eff, rx_rise_i));
  assign nxt_slot_o  = nxt_slot;
  assign word_stb_o  = (slot_q == '0);
  assign nib_clk_o   = (n_cur == ndiv_t'(1)) || (ndiv_t'(phase_q) < (n_cur >> 1));
  assign phase_o     = phase_q;
  assign slot_o      = slot_q;
  assign n_o         = n_cur;
  assign resync_o    = resync;
endmodule

// File: rtl/nwl_tx_deser.sv
module nwl_tx_deser
  import nwl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cap_i,
  input  slot_t slot_i,
  input  nib_t  nib_i,
  input  logic  one_sign_i,
  output word_t word_o,
  output logic  valid_o
);
  nib_t  part_q [SLOTS-1];
  word_t full;
  word_t word_q;
  logic  valid_q;
  logic  last_cap;

  for (genvar g = 0; g < SLOTS - 1; g++) begin : g_part
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            part_q[g] <= '0;
      else if (cap_i && slot_i == slot_t'(g)) part_q[g] <= nib_i;
    end
  end

  assign last_cap = cap_i && (slot_i == slot_t'(SLOTS - 1));

  always_comb begin
    full = '0;
    for (int s = 0; s < SLOTS - 1; s++) full[s*LANES +: LANES] = part_q[s];
    full[(SLOTS-1)*LANES +: LANES] = nib_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= last_cap;
      if (last_cap) word_q <= fmt_word(full, one_sign_i);
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/nwl_rx_ser.sv
module nwl_rx_ser
  import nwl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  launch_i,
  input  slot_t nxt_slot_i,
  input  word_t src_i,
  input  logic  one_sign_i,
  output nib_t  nib_o
);
  word_t hold_q;
  word_t src_fmt;
  nib_t  nib_q;

  assign src_fmt = fmt_word(src_i, one_sign_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      nib_q  <= '0;
    end else if (launch_i) begin
      if (nxt_slot_i == '0) begin
        hold_q <= src_fmt;
        nib_q  <= nib_of(src_fmt, '0);
      end else begin
        nib_q  <= nib_of(hold_q, nxt_slot_i);
      end
    end
  end

  assign nib_o = nib_q;
endmodule

// File: rtl/nwl_link.sv
module nwl_link
  import nwl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             one_sign_i,
  input  logic             tx_rise_i,
  input  logic             rx_rise_i,
  input  logic             loop_i,
  input  logic [LANES-1:0] tx_nib_i,
  output logic [WORD_W-1:0] tx_word_o,
  output logic             tx_valid_o,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic [LANES-1:0] rx_nib_o,
  output logic             word_stb_o,
  output logic             nib_clk_o
);
  phase_t phase_w;
  slot_t  slot_w, nxt_slot_w;
  ndiv_t  n_w;
  logic   resync_w, tx_cap_w, rx_launch_w;
  word_t  tx_word_w, rx_src_w;

  nwl_timebase u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_sel_i  (div_sel_i),
    .tx_rise_i  (tx_rise_i),
    .rx_rise_i  (rx_rise_i),
    .phase_o    (phase_w),
    .slot_o     (slot_w),
    .n_o        (n_w),
    .resync_o   (resync_w),
    .tx_cap_o   (tx_cap_w),
    .rx_launch_o(rx_launch_w),
    .nxt_slot_o (nxt_slot_w),
    .word_stb_o (word_stb_o),
    .nib_clk_o  (nib_clk_o)
  );

  nwl_tx_deser u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_i     (tx_cap_w),
    .slot_i    (slot_w),
    .nib_i     (tx_nib_i),
    .one_sign_i(one_sign_i),
    .word_o    (tx_word_w),
    .valid_o   (tx_valid_o)
  );

  assign rx_src_w = loop_i ? tx_word_w : rx_word_i;

  nwl_rx_ser u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch_i  (rx_launch_w),
    .nxt_slot_i(nxt_slot_w),
    .src_i     (rx_src_w),
    .one_sign_i(one_sign_i),
    .nib_o     (rx_nib_o)
  );

  assign tx_word_o = tx_word_w;
endmodule

// File: rtl/nwl_link_chk.sv
module nwl_link_chk
  import nwl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              resync,
  input phase_t            phase,
  input slot_t             slot,
  input ndiv_t             n_cur,
  input logic              one_sign_i,
  input logic              rx_rise_i,
  input logic              word_stb_o,
  input logic              tx_valid_o,
  input logic [WORD_W-1:0] tx_word_o,
  input logic [LANES-1:0]  rx_nib_o
);
  // R10: a divider change restarts the word at slot 0, phase 0
  p_resync_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (word_stb_o && phase == '0));

  // R5: the transmit valid is a single-cycle pulse
  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |=> !tx_valid_o);

  // R5: a valid pulse follows a cycle spent in the last slot
  p_valid_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> ($past(slot) == slot_t'(SLOTS - 1)));

  // R8: two-sign words come out with equal top bits
  p_two_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !$past(one_sign_i)) |-> (tx_word_o[WORD_W-1] == tx_word_o[WORD_W-2]));

  // R6: the receive nibble moves only at its launch phase
  p_rx_change_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_nib_o) |-> (ndiv_t'(phase) == ($past(rx_rise_i) ? (n_cur >> 1) : ndiv_t'(0))));
endmodule

bind nwl_link nwl_link_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .resync    (resync_w),
  .phase     (phase_w),
  .slot      (slot_w),
  .n_cur     (n_w),
  .one_sign_i(one_sign_i),
  .rx_rise_i (rx_rise_i),
  .word_stb_o(word_stb_o),
  .tx_valid_o(tx_valid_o),
  .tx_word_o (tx_word_o),
  .rx_nib_o  (rx_nib_o)
);

// File: tb/nwl_link_tb_top.sv
`timescale 1ns/1ps
module nwl_link_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  div_sel = 2'd0;
  logic        one_sign = 1'b1, tx_rise = 1'b0, rx_rise = 1'b0, loop_en = 1'b0;
  logic [3:0]  tx_nib = 4'h0;
  logic [15:0] tx_word, rx_word = 16'h0;
  logic        tx_valid, word_stb, nib_clk;
  logic [3:0]  rx_nib;

  int checks = 0, failures = 0, wd_cnt = 0;
  int cyc = 0, vcount = 0, last_delay = 0, start_cyc = 0;
  logic [15:0] last_word = 16'h0;
  logic        prev_stb = 1'b1;

  always #5 clk = ~clk;

  nwl_link dut_i (
    .clk(clk), .rst_n(rst_n), .div_sel_i(div_sel), .one_sign_i(one_sign),
    .tx_rise_i(tx_rise), .rx_rise_i(rx_rise), .loop_i(loop_en),
    .tx_nib_i(tx_nib), .tx_word_o(tx_word), .tx_valid_o(tx_valid),
    .rx_word_i(rx_word), .rx_nib_o(rx_nib), .word_stb_o(word_stb), .nib_clk_o(nib_clk)
  );

  // monitor: valid pulses, their words and their distance from the word start
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; prev_stb = 1'b1; start_cyc = 0;
    end else begin
      cyc++;
      if (tx_valid) begin
        vcount++;
        last_word  = tx_word;
        last_delay = cyc - start_cyc;
      end
      if (word_stb && !prev_stb) start_cyc = cyc;
      prev_stb = word_stb;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt == 100000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", wd_cnt);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] fmt_exp(input logic [15:0] w, input logic one);
    return one ? w : {w[15], w[15], w[13:0]};
  endfunction

  task automatic wait_word_start();
    logic p;
    forever begin
      p = word_stb;
      @(negedge clk);
      if (word_stb && !p) break;
    end
  endtask

  task automatic set_cfg(input logic [1:0] sel, input logic one, input logic txr,
                         input logic rxr, input logic lp);
    div_sel = sel; one_sign = one; tx_rise = txr; rx_rise = rxr; loop_en = lp;
    wait_word_start();
    wait_word_start();
  endtask

  task automatic drive_word(input logic [15:0] w, input int n);
    for (int s = 0; s < 4; s++) begin
      tx_nib = w[4*s +: 4];
      repeat (n) @(negedge clk);
    end
  endtask

  task automatic chk_rx_frame(input logic [15:0] fw, input int n, input int loff,
                              input logic [3:0] prevnib, input string req);
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < n; p++) begin
        logic [3:0] e;
        if (p >= loff)   e = fw[4*s +: 4];
        else if (s == 0) e = prevnib;
        else             e = fw[4*(s-1) +: 4];
        chk(req, $sformatf("rx nibble slot %0d phase %0d", s, p), rx_nib, e);
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "strobe in reset", word_stb, 1);
    chk("R1", "valid in reset", tx_valid, 0);
    chk("R1", "rx nibble in reset", rx_nib, 0);
    rst_n = 1'b1;
    #1 chk("R1", "strobe in release cycle", word_stb, 1);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      chk("R1", $sformatf("strobe cycle %0d after release", i), word_stb, (i == 4) ? 1 : 0);
    end
  endtask

  task automatic t_strobe(input logic [1:0] sel);
    int n;
    n = 1 << sel;
    set_cfg(sel, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i <= 4*n; i++) begin
      chk("R2", $sformatf("strobe N=%0d cycle %0d", n, i), word_stb, ((i % (4*n)) < n) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_nibclk(input logic [1:0] sel);
    int n;
    n = 1 << sel;
    set_cfg(sel, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 2*n; i++) begin
      int exp;
      exp = (n == 1) ? 1 : (((i % n) < n/2) ? 1 : 0);
      chk("R3", $sformatf("nibble clock N=%0d cycle %0d", n, i), nib_clk, exp);
      @(negedge clk);
    end
  endtask

  task automatic t_tx(input logic [1:0] sel, input logic rise, input logic one,
                      input logic [15:0] w);
    int n, off, snap;
    n = 1 << sel;
    off = rise ? n - 1 : n / 2;
    set_cfg(sel, one, rise, 1'b0, 1'b0);
    tx_nib = w[3:0];
    repeat (n) @(negedge clk);
    snap = vcount;
    for (int s = 1; s < 4; s++) begin
      tx_nib = w[4*s +: 4];
      repeat (n) @(negedge clk);
    end
    tx_nib = 4'h0;
    repeat (n + 1) @(negedge clk);
    chk("R5", $sformatf("one valid pulse N=%0d", n), vcount - snap, 1);
    chk("R5", $sformatf("valid delay N=%0d rise=%0d", n, rise), last_delay, 3*n + off + 1);
    chk("R4", $sformatf("assembled word N=%0d", n), last_word, fmt_exp(w, one));
    chk("R8", $sformatf("tx sign format one=%0d", one), tx_word, fmt_exp(w, one));
  endtask

  task automatic t_rx(input logic [1:0] sel, input logic rise, input logic one,
                      input logic [15:0] w);
    int n, loff;
    logic [15:0] fw;
    n = 1 << sel;
    loff = rise ? n / 2 : 0;
    fw = fmt_exp(w, one);
    rx_word = w;
    set_cfg(sel, one, 1'b0, rise, 1'b0);
    chk_rx_frame(fw, n, loff, fw[15:12], $sformatf("R4 R6 R7 R8 N=%0d", n));
  endtask

  task automatic t_loop();
    logic [15:0] w;
    w = 16'h9A5C;
    rx_word = 16'h1111;
    set_cfg(2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    drive_word(w, 2);
    drive_word(w, 2);
    fork
      drive_word(w, 2);
      chk_rx_frame(fmt_exp(w, 1'b0), 2, 0, 4'h0, "R9 loopback");
    join
    tx_nib = 4'h0;
  endtask

  task automatic t_resync();
    int snap;
    set_cfg(2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    tx_nib = 4'hF;
    repeat (4) @(negedge clk);
    snap = vcount;
    div_sel = 2'd2;
    @(negedge clk);
    chk("R10", "strobe right after divider change", word_stb, 1);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      chk("R10", $sformatf("strobe cycle %0d with new N", i), word_stb, (i < 4) ? 1 : 0);
    end
    repeat (2) @(negedge clk);
    chk("R10", "no valid for dropped word", vcount - snap, 0);
    tx_nib = 4'h0;
  endtask

  initial begin
    t_reset();
    for (int c = 0; c < 4; c++) t_strobe(2'(c));
    t_nibclk(2'd0);
    t_nibclk(2'd2);
    t_nibclk(2'd3);
    t_tx(2'd0, 1'b0, 1'b1, 16'h7FFF);
    t_tx(2'd1, 1'b1, 1'b0, 16'hA5C3);
    t_tx(2'd3, 1'b0, 1'b1, 16'h8000);
    t_tx(2'd2, 1'b1, 1'b1, 16'h1234);
    t_rx(2'd0, 1'b0, 1'b1, 16'h3C5A);
    t_rx(2'd2, 1'b1, 1'b0, 16'h4001);
    t_rx(2'd3, 1'b0, 1'b1, 16'h8000);
    t_rx(2'd1, 1'b1, 1'b1, 16'hFEDC);
    t_loop();
    t_resync();
    t_tx(2'd2, 1'b0, 1'b1, 16'h0F0F);
    summary();
    $finish;
  end
endmodule